// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small accumulator-style processor. Each operation takes an operation code, the accumulator byte, the index (X) byte, an operand byte and the current status byte. It returns a result byte, a new index byte and an updated status byte. The arithmetic needs a single adder, which is shared by add, subtract, compare and a fused "accumulator AND index, minus operand" operation. Logic operations, shifts, rotates, increment and decrement sit in their own small units.

The computation is purely combinational. A thin registered stage captures the outputs one cycle after an accepted request, so that the block can drop into a pipeline and be observed at clean clock edges.

The status byte holds N at bit 7, V at bit 6, a spare bit at bit 5, B at bit 4, D at bit 3, I at bit 2, Z at bit 1 and C at bit 0. The spare, B, D and I bits are never changed. Decimal arithmetic is not performed.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (add) gives res = (A + M + C) mod 256, with C at status bit 0. The new C is bit 8 of the 9-bit sum. The new V (bit 6) is set when A and M have equal bit 7 and res bit 7 differs from A bit 7.
- R2: Op code 1 (subtract) gives res = (A − M − (1 − C)) mod 256. The new C is 1 exactly when no borrow occurs. The new V is set when A and M differ in bit 7 and res bit 7 differs from A bit 7.
- R3: Op code 2 (compare) leaves res equal to A. N (bit 7) and Z (bit 1) are taken from the low byte of A − M, C is set when A ≥ M, and V is unchanged.
- R4: Op code 3 (bit test) leaves res equal to A. Z is set when (A AND M) is zero, N is copied from M bit 7, V is copied from M bit 6, and C is unchanged.
- R5: Op codes 4, 5 and 6 give A AND M, A OR M and A XOR M. Only N and Z change.
- R6: Op code 7 (shift left) gives res = (M << 1) mod 256 with C = M bit 7. Op code 8 (logical shift right) gives res = M >> 1 with C = M bit 0, which always leaves N clear.
- R7: Op code 9 (rotate left) puts the old C into res bit 0 and M bit 7 into C. Op code 10 (rotate right) puts the old C into res bit 7 and M bit 0 into C.
- R8: Op codes 11 and 12 give M + 1 and M − 1, wrapping modulo 256. Only N and Z change.
- R9: Op code 13 (fused) writes the low byte of (A AND X) − M to the index output and leaves res equal to A. N and Z come from that byte, C is set when (A AND X) ≥ M, and V is unchanged.
- R10: N equals result bit 7 and Z is set for a zero result on every operation that affects them. Status bits 5 to 2, and every flag an operation does not name, pass through unchanged. The index output equals X for every op code except 13.
- R11: Outputs update on the clock edge at which in_valid is high, with out_valid high for the following cycle. Without in_valid the outputs hold. Synchronous reset clears all outputs to zero.
- R12: Op codes 14 and 15 leave res equal to A and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; inputs are captured on this edge |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator byte (A) |
| xr_in | input | 8 | Index byte (X) |
| opnd_in | input | 8 | Operand byte (M) |
| stat_in | input | 8 | Current status byte |
| out_valid | output | 1 | High one cycle after an accepted request |
| res_out | output | 8 | Result byte |
| xr_out | output | 8 | New index byte |
| stat_out | output | 8 | New status byte |

## Verification
Most internal faults in this block show up on the very next output cycle after the faulty operation. Examples are a wrongly inverted borrow, a sign test taken from the wrong operand, or a shift that picks the wrong bit into carry. Each would appear as a wrong res_out or a wrong flag bit, and none of them accumulates or stays hidden, because the block keeps no state between requests. A fault in flag selection is harder to see: a pass-through bit being overwritten only shows when the incoming status has that bit set. For that reason the status inputs are varied on every request. A hold fault, where the registers load without a request, shows at the first idle cycle after the inputs change.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int STAT_W = 8;
    localparam int OP_W   = 4;

    localparam int FLAG_N = 7;
    localparam int FLAG_V = 6;
    localparam int FLAG_Z = 1;
    localparam int FLAG_C = 0;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_CMP = 4'd2,
        OP_BIT = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10,
        OP_INC = 4'd11,
        OP_DEC = 4'd12,
        OP_AXS = 4'd13
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic v;
        logic spare;
        logic brk;
        logic dec;
        logic irq_mask;
        logic z;
        logic c;
    } stat_t;

    typedef enum logic [2:0] {
        UN_SHL = 3'd0,
        UN_SHR = 3'd1,
        UN_ROL = 3'd2,
        UN_ROR = 3'd3,
        UN_INC = 3'd4,
        UN_DEC = 3'd5
    } unary_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_e;

    function automatic unary_e unary_kind(input logic [OP_W-1:0] op);
        logic [OP_W-1:0] d;
        d = op - OP_SHL;
        return unary_e'(d[2:0]);
    endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    // Subtraction as A + ~B + carry: carry out then means "no borrow".
    assign b_eff  = sub_i ? ~b_i : b_i;
    assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
    assign sum_o  = full[W-1:0];
    assign cout_o = full[W];
    assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic_e       sel_i,
    output logic [W-1:0] val_o
);
    always_comb begin
        unique case (sel_i)
            LG_OR:   val_o = a_i | m_i;
            LG_XOR:  val_o = a_i ^ m_i;
            default: val_o = a_i & m_i;
        endcase
    end
endmodule

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] m_i,
    input  logic         cin_i,
    input  unary_e       kind_i,
    output logic [W-1:0] val_o,
    output logic         cout_o
);
    always_comb begin
        val_o  = m_i;
        cout_o = cin_i;
        case (kind_i)
            UN_SHL: begin val_o = {m_i[W-2:0], 1'b0};  cout_o = m_i[W-1]; end
            UN_SHR: begin val_o = {1'b0, m_i[W-1:1]};  cout_o = m_i[0];   end
            UN_ROL: begin val_o = {m_i[W-2:0], cin_i}; cout_o = m_i[W-1]; end
            UN_ROR: begin val_o = {cin_i, m_i[W-1:1]}; cout_o = m_i[0];   end
            UN_INC: val_o = m_i + {{(W-1){1'b0}}, 1'b1};
            UN_DEC: val_o = m_i - {{(W-1){1'b0}}, 1'b1};
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [W-1:0]      acc_in,
    input  logic [W-1:0]      xr_in,
    input  logic [W-1:0]      opnd_in,
    input  logic [STAT_W-1:0] stat_in,
    output logic              out_valid,
    output logic [W-1:0]      res_out,
    output logic [W-1:0]      xr_out,
    output logic [STAT_W-1:0] stat_out
);
    stat_t        st_in;
    stat_t        st_nx;
    logic [W-1:0] res_nx;
    logic [W-1:0] xr_nx;
    logic [W-1:0] nz_src;
    logic         upd_nz;

    assign st_in = stat_t'(stat_in);

    // Shared adder: add / subtract use the incoming carry; compare and the
    // fused op always subtract with no borrow-in.
    logic         is_cmp_like;
    logic [W-1:0] as_a;
    logic         as_cin;
    logic         as_sub;
    logic [W-1:0] as_sum;
    logic         as_cout;
    logic         as_ovf;

    assign is_cmp_like = (op_sel == OP_CMP) || (op_sel == OP_AXS);
    assign as_a   = (op_sel == OP_AXS) ? (acc_in & xr_in) : acc_in;
    assign as_sub = (op_sel != OP_ADD);
    assign as_cin = is_cmp_like ? 1'b1 : st_in.c;

    acc_alu_addsub #(.W(W)) u_addsub (
        .a_i(as_a), .b_i(opnd_in), .cin_i(as_cin), .sub_i(as_sub),
        .sum_o(as_sum), .cout_o(as_cout), .ovf_o(as_ovf)
    );

    logic_e       lg_sel;
    logic [W-1:0] lg_val;

    always_comb begin
        case (op_sel)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    acc_alu_logic #(.W(W)) u_logic (
        .a_i(acc_in), .m_i(opnd_in), .sel_i(lg_sel), .val_o(lg_val)
    );

    unary_e       un_kind;
    logic [W-1:0] un_val;
    logic         un_cout;

    assign un_kind = unary_kind(op_sel);

    acc_alu_unary #(.W(W)) u_unary (
        .m_i(opnd_in), .cin_i(st_in.c), .kind_i(un_kind),
        .val_o(un_val), .cout_o(un_cout)
    );

    always_comb begin
        res_nx = acc_in;
        xr_nx  = xr_in;
        st_nx  = st_in;
        nz_src = acc_in;
        upd_nz = 1'b0;
        case (op_sel)
            OP_ADD, OP_SUB: begin
                res_nx  = as_sum;
                st_nx.c = as_cout;
                st_nx.v = as_ovf;
                nz_src  = as_sum;
                upd_nz  = 1'b1;
            end
            OP_CMP: begin
                st_nx.c = as_cout;
                nz_src  = as_sum;
                upd_nz  = 1'b1;
            end
            OP_AXS: begin
                xr_nx   = as_sum;
                st_nx.c = as_cout;
                nz_src  = as_sum;
                upd_nz  = 1'b1;
            end
            OP_BIT: begin
                st_nx.n = opnd_in[W-1];
                st_nx.v = opnd_in[W-2];
                st_nx.z = (lg_val == '0);
            end
            OP_AND, OP_OR, OP_XOR: begin
                res_nx = lg_val;
                nz_src = lg_val;
                upd_nz = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                res_nx  = un_val;
                st_nx.c = un_cout;
                nz_src  = un_val;
                upd_nz  = 1'b1;
            end
            OP_INC, OP_DEC: begin
                res_nx = un_val;
                nz_src = un_val;
                upd_nz = 1'b1;
            end
            default: ;
        endcase
        if (upd_nz) begin
            st_nx.n = nz_src[W-1];
            st_nx.z = (nz_src == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_out   <= '0;
            xr_out    <= '0;
            stat_out  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_out  <= res_nx;
                xr_out   <= xr_nx;
                stat_out <= st_nx;
            end
        end
    end

    // R10: control bits 5..2 never change
    assert_ctrl_bits_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> stat_out[5:2] == $past(stat_in[5:2]));

    // R10: index output only moves on the fused op
    assert_xr_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op_sel) != OP_AXS) |-> xr_out == $past(xr_in));

    // R4: bit test copies operand bits, keeps accumulator and carry
    assert_bit_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op_sel) == OP_BIT) |->
        (stat_out[FLAG_N] == $past(opnd_in[W-1]) && stat_out[FLAG_V] == $past(opnd_in[W-2])
         && res_out == $past(acc_in) && stat_out[FLAG_C] == $past(stat_in[FLAG_C])));

    // R6: logical shift right never leaves N set
    assert_shr_nclear_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op_sel) == OP_SHR) |-> !stat_out[FLAG_N]);

    // R3 / R9: compare-style ops keep the accumulator and V
    assert_cmp_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op_sel) == OP_CMP || $past(op_sel) == OP_AXS)) |->
        (res_out == $past(acc_in) && stat_out[FLAG_V] == $past(stat_in[FLAG_V])));

    // R11: outputs hold when no request was taken
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> ($stable(res_out) && $stable(xr_out) && $stable(stat_out)));

    // R12: reserved codes are no-ops
    assert_reserved_R12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(op_sel) > OP_AXS) |->
        (res_out == $past(acc_in) && stat_out == $past(stat_in)));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] xr_in = '0;
    logic [7:0] opnd_in = '0;
    logic [7:0] stat_in = '0;
    logic       out_valid;
    logic [7:0] res_out;
    logic [7:0] xr_out;
    logic [7:0] stat_out;

    always #4 clk = ~clk;

    acc_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .acc_in(acc_in), .xr_in(xr_in), .opnd_in(opnd_in), .stat_in(stat_in),
        .out_valid(out_valid), .res_out(res_out), .xr_out(xr_out), .stat_out(stat_out)
    );

    typedef struct {
        logic [7:0] res;
        logic [7:0] xr;
        logic [7:0] st;
        string      tag;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0;
    int          errors = 0;
    logic [7:0]  last_res = '0;
    logic [7:0]  last_xr = '0;
    logic [7:0]  last_st = '0;
    logic [31:0] seed = 32'h1234_5678;

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t model(input int op, input int a, input int x, input int m, input logic [7:0] si);
        exp_t e;
        int   t;
        int   r;
        int   c;
        logic nz;
        logic [7:0] s;
        s = si; r = a; c = int'(si[0]); nz = 1'b1;
        e.xr = x[7:0];
        case (op)
            0: begin t = a + m + c; r = t % 256; s[0] = (t >= 256);
                     s[6] = (a[7] == m[7]) && (r[7] != a[7]); e.tag = "R1"; end
            1: begin t = a - m - (1 - c); r = (t + 512) % 256; s[0] = (t >= 0);
                     s[6] = (a[7] != m[7]) && (r[7] != a[7]); e.tag = "R2"; end
            2: begin t = (a - m + 256) % 256; s[0] = (a >= m); nz = 1'b0;
                     s[7] = t[7]; s[1] = (t == 0); e.tag = "R3"; end
            3: begin nz = 1'b0; s[1] = ((a & m) == 0); s[7] = m[7]; s[6] = m[6]; e.tag = "R4"; end
            4: begin r = a & m; e.tag = "R5"; end
            5: begin r = a | m; e.tag = "R5"; end
            6: begin r = a ^ m; e.tag = "R5"; end
            7: begin r = (m * 2) % 256; s[0] = m[7]; e.tag = "R6"; end
            8: begin r = m / 2; s[0] = m[0]; e.tag = "R6"; end
            9: begin r = (m * 2 + c) % 256; s[0] = m[7]; e.tag = "R7"; end
            10: begin r = m / 2 + c * 128; s[0] = m[0]; e.tag = "R7"; end
            11: begin r = (m + 1) % 256; e.tag = "R8"; end
            12: begin r = (m + 255) % 256; e.tag = "R8"; end
            13: begin t = ((a & x) - m + 256) % 256; e.xr = t[7:0]; s[0] = ((a & x) >= m);
                      nz = 1'b0; s[7] = t[7]; s[1] = (t == 0); e.tag = "R9"; end
            default: begin nz = 1'b0; e.tag = "R12"; end
        endcase
        if (nz && op != 3) begin
            s[7] = r[7];
            s[1] = (r == 0);
        end
        e.res = r[7:0];
        e.st  = s;
        return e;
    endfunction

    task automatic send(input int op, input int a, input int x, input int m, input logic [7:0] s);
        @(negedge clk);
        op_sel   = op[3:0];
        acc_in   = a[7:0];
        xr_in    = x[7:0];
        opnd_in  = m[7:0];
        stat_in  = s;
        in_valid = 1'b1;
        sbq.push_back(model(op, a, x, m, s));
    endtask

    function automatic logic [7:0] rnd8();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed[23:16];
    endfunction

    // Monitor: pops one expected item per valid output
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sbq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected out_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(e.tag, "res", res_out, e.res);
                chk((e.tag == "R9") ? "R9" : "R10", "xr", xr_out, e.xr);
                chk(e.tag, "status", stat_out, e.st);
                last_res = e.res; last_xr = e.xr; last_st = e.st;
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R11: reset state
        chk("R11", "reset res", res_out, 8'h00);
        chk("R11", "reset xr", xr_out, 8'h00);
        chk("R11", "reset status", stat_out, 8'h00);
        chk("R11", "reset valid", {7'd0, out_valid}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        // R1 add: signed overflow, unsigned carry, carry-in
        send(0, 8'h50, 8'h00, 8'h50, 8'h20);
        send(0, 8'hFF, 8'h00, 8'h01, 8'h24);
        send(0, 8'h10, 8'h00, 8'h20, 8'h01);
        send(0, 8'h80, 8'h00, 8'h80, 8'h3C);
        // R2 subtract: borrow, overflow, borrow-in
        send(1, 8'h50, 8'h00, 8'hF0, 8'h01);
        send(1, 8'h80, 8'h00, 8'h01, 8'h01);
        send(1, 8'h05, 8'h00, 8'h05, 8'h00);
        send(1, 8'h05, 8'h00, 8'h05, 8'h41);
        // R3 compare: equal, less, greater
        send(2, 8'h42, 8'h00, 8'h42, 8'h40);
        send(2, 8'h10, 8'h00, 8'h20, 8'h01);
        send(2, 8'hC0, 8'h00, 8'h01, 8'h00);
        // R4 bit test
        send(3, 8'h0F, 8'h00, 8'hC0, 8'h01);
        send(3, 8'hFF, 8'h00, 8'h01, 8'hC2);
        // R5 logic
        send(4, 8'hF0, 8'h00, 8'h0F, 8'h00);
        send(5, 8'h80, 8'h00, 8'h01, 8'h02);
        send(6, 8'hAA, 8'h00, 8'hAA, 8'h80);
        // R6 shifts
        send(7, 8'h00, 8'h00, 8'h80, 8'h00);
        send(8, 8'h00, 8'h00, 8'hFF, 8'h80);
        // R7 rotates with carry in set and clear
        send(9, 8'h00, 8'h00, 8'h40, 8'h01);
        send(10, 8'h00, 8'h00, 8'h01, 8'h01);
        send(10, 8'h00, 8'h00, 8'h02, 8'h00);
        // R8 wrap
        send(11, 8'h00, 8'h00, 8'hFF, 8'h00);
        send(12, 8'h00, 8'h00, 8'h00, 8'h01);
        // R9 fused
        send(13, 8'hF3, 8'h3F, 8'h33, 8'h40);
        send(13, 8'h0F, 8'hFF, 8'h10, 8'h01);
        // R12 reserved
        send(14, 8'h12, 8'h34, 8'h56, 8'hFF);
        send(15, 8'h00, 8'h00, 8'h00, 8'h5A);

        // R11: idle with changing inputs, outputs must hold
        @(negedge clk);
        in_valid = 1'b0;
        acc_in = 8'h99; opnd_in = 8'h66; stat_in = 8'hFF; op_sel = 4'd0;
        repeat (2) @(negedge clk);
        #1;
        chk("R11", "hold res", res_out, last_res);
        chk("R11", "hold xr", xr_out, last_xr);
        chk("R11", "hold status", stat_out, last_st);
        chk("R11", "idle valid", {7'd0, out_valid}, 8'h00);

        // R10: sweep all codes with varied status bits
        for (int i = 0; i < 640; i++) begin
            send(i % 16, rnd8(), rnd8(), rnd8(), rnd8());
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        if (sbq.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11 pending actual=%0d expected=0", sbq.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule